// File: doc/BRIEF.md
# Banked Priority Mask Register Unit

This block holds the interrupt-masking special registers of a small microcontroller core. It also derives the current execution priority from them. A single register-select port serves move-to and move-from special register operations. On this port a write is taken on the clock edge and a read returns the selected register combinationally.

The base-priority mask is kept in two banks. The core's security-state input chooses which bank every access and the priority resolution use. A second write alias of the base-priority mask can only tighten masking. The unit resolves a signed execution priority in fixed precedence: fault mask first, then the interrupt-disable bit, then the selected base-priority value filtered by an externally supplied group-priority mask. When none of these applies it gives a no-exception level. The interrupt controller consumes this priority.

Top module: `prio_mask_unit`

## Requirements
- R1: After reset every mask register in both banks is zero, reads of select codes 16 to 19 return 0, and `exec_prio` is 256.
- R2: A write to select code 16 (interrupt-disable bit) keeps only bit 0 of the data. A read of code 16 returns that bit zero-extended to 32 bits.
- R3: A write to select code 19 (fault mask) keeps only bit 0 of the data. A read of code 19 returns that bit zero-extended.
- R4: A write to select code 17 stores data bits 7:0 unconditionally into the bank chosen by `sec_state` (0 = non-secure bank, 1 = secure bank). Reads of code 17 or 18 return the chosen bank zero-extended.
- R5: A write that targets one base-priority bank leaves the other bank unchanged.
- R6: A write to select code 18 takes data bits 7:0. It updates the chosen bank only when that value is nonzero and either is smaller than the stored value or the stored value is zero. In every other case the write has no effect.
- R7: While the fault mask is set, `exec_prio` is -1 (all ones), whatever the other registers hold.
- R8: While the fault mask is clear and the interrupt-disable bit is set, `exec_prio` is 0.
- R9: While both single-bit masks are clear and the chosen bank is nonzero, `exec_prio` equals that bank ANDed with `grp_mask`, zero-extended. This can give 0 when the mask clears all set bits.
- R10: While both single-bit masks are clear and the chosen bank is zero, `exec_prio` is 256.
- R11: Select codes other than 16 to 19 read as zero, and writes to them change no register.
- R12: A write and a priority evaluation in the same cycle use the old register value. The new value shows on `exec_prio` and `rd_data` after the next rising clock edge.
- R13: With `HAS_SEC` = 0, `sec_state` is ignored and every access and the priority resolution use the non-secure bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_state | input | 1 | Current security state, selects the base-priority bank |
| grp_mask | input | 8 | Group-priority mask applied to the base-priority value |
| sel | input | 8 | Special register select code |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| exec_prio | output | 10 | Signed execution priority |

## Verification
The raise-only alias is driven with a zero value, a value above the stored one, a value below it, an equal value, and a value whose low byte is zero. This separates a correct comparison from one that is inverted, non-strict, or missing the zero-guard. Bank selection is tested by writing one bank and reading back both states, which exposes a swapped or shared bank. The priority precedence is tested with masks layered one on top of another and then removed. A group mask that clears the sub-priority bits shows whether the AND is applied. A second instance built without the security extension shows that the state input is ignored there.

// File: rtl/prio_mask_unit.sv
module prio_mask_unit #(
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 8,
  parameter int EXEC_W  = 10,
  parameter int SEL_W   = 8,
  parameter bit HAS_SEC = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sec_state,
  input  logic [PRIO_W-1:0]        grp_mask,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data,
  output logic signed [EXEC_W-1:0] exec_prio
);
  localparam logic [SEL_W-1:0] SEL_PMASK = SEL_W'(16);
  localparam logic [SEL_W-1:0] SEL_BASE  = SEL_W'(17);
  localparam logic [SEL_W-1:0] SEL_RAISE = SEL_W'(18);
  localparam logic [SEL_W-1:0] SEL_FMASK = SEL_W'(19);
  localparam logic signed [EXEC_W-1:0] PRIO_NONE = EXEC_W'(1 << PRIO_W);
  localparam logic signed [EXEC_W-1:0] PRIO_FAULT = '1;

  logic [1:0][PRIO_W-1:0] bpri_q;
  logic                   pmask_q, fmask_q;
  logic                   bank;
  logic [PRIO_W-1:0]      cur, wval;
  logic                   raise_ok;
  logic                   unused;

  assign bank     = HAS_SEC ? sec_state : 1'b0;
  assign cur      = bpri_q[bank];
  assign wval     = wr_data[PRIO_W-1:0];
  assign raise_ok = (wval != '0) && ((wval < cur) || (cur == '0));
  assign unused   = ^wr_data[DATA_W-1:PRIO_W] ^ (HAS_SEC ? 1'b0 : sec_state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpri_q  <= '0;
      pmask_q <= 1'b0;
      fmask_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_PMASK: pmask_q <= wr_data[0];
        SEL_FMASK: fmask_q <= wr_data[0];
        SEL_BASE:  bpri_q[bank] <= wval;
        SEL_RAISE: if (raise_ok) bpri_q[bank] <= wval;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PMASK:           rd_data = DATA_W'(pmask_q);
      SEL_FMASK:           rd_data = DATA_W'(fmask_q);
      SEL_BASE, SEL_RAISE: rd_data = DATA_W'(cur);
      default:             rd_data = '0;
    endcase
  end

  always_comb begin
    if (fmask_q)          exec_prio = PRIO_FAULT;
    else if (pmask_q)     exec_prio = '0;
    else if (cur != '0)   exec_prio = EXEC_W'(cur & grp_mask);
    else                  exec_prio = PRIO_NONE;
  end
endmodule

module prio_mask_unit_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_en,
  input logic              bank,
  input logic [7:0]        sel,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [1:0][7:0]   bpri_q,
  input logic              pmask_q,
  input logic              fmask_q,
  input logic [9:0]        exec_prio
);
  p_fault_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == 8'd19 && wr_data[0] |=> exec_prio == 10'h3FF);

  p_pmask_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == 8'd16 && wr_data[0] && !fmask_q |=> exec_prio == 10'd0);

  p_base_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == 8'd17 |=> bpri_q[$past(bank)] == $past(wr_data[7:0]));

  p_other_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (sel == 8'd17 || sel == 8'd18) |=>
      ($past(bank) ? bpri_q[0] == $past(bpri_q[0]) : bpri_q[1] == $past(bpri_q[1])));

  p_raise_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && sel == 8'd18 |=>
      (bpri_q[$past(bank)] == $past(bpri_q[bank])) ||
      (bpri_q[$past(bank)] != 8'd0 &&
       (bpri_q[$past(bank)] < $past(bpri_q[bank]) || $past(bpri_q[bank]) == 8'd0)));

  p_unknown_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (sel < 8'd16 || sel > 8'd19) |=>
      $stable(bpri_q) && $stable(pmask_q) && $stable(fmask_q));

  p_single_bank_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |-> bpri_q[1] == 8'd0);
endmodule

bind prio_mask_unit prio_mask_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_en(HAS_SEC), .bank(bank), .sel(sel),
  .wr_en(wr_en), .wr_data(wr_data), .bpri_q(bpri_q), .pmask_q(pmask_q),
  .fmask_q(fmask_q), .exec_prio(exec_prio)
);

// File: tb/prio_mask_unit_tb.sv
module prio_mask_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_state = 1'b0;
  logic [7:0]  grp_mask = 8'hFF;
  logic [7:0]  sel = 8'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_data_ns;
  logic signed [9:0] exec_prio, exec_prio_ns;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_mask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .grp_mask(grp_mask),
    .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .exec_prio(exec_prio));

  prio_mask_unit #(.HAS_SEC(1'b0)) u_dut_ns (
    .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .grp_mask(grp_mask),
    .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data_ns),
    .exec_prio(exec_prio_ns));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; sec_state = 1'b0; grp_mask = 8'hFF;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] s, input logic [31:0] d);
    @(negedge clk);
    sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] s, output logic [31:0] v);
    sel = s; wr_en = 1'b0;
    #1 v = rd_data;
  endtask

  function automatic logic [31:0] ep(input logic [9:0] p);
    return {22'd0, p};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int c = 16; c <= 19; c++) begin
      rd(8'(c), v);
      chk("R1 read", v, 32'd0);
    end
    chk("R1 exec_prio", ep(exec_prio), 32'd256);
  endtask

  task automatic t_single_masks();
    logic [31:0] v;
    do_reset();
    wr(8'd16, 32'hFFFF_FFFE);
    rd(8'd16, v); chk("R2 bit0 only (clear)", v, 32'd0);
    wr(8'd16, 32'h0000_0003);
    rd(8'd16, v); chk("R2 bit0 only (set)", v, 32'd1);
    chk("R8 pmask gives 0", ep(exec_prio), 32'd0);
    wr(8'd19, 32'hFFFF_FFFF);
    rd(8'd19, v); chk("R3 fault read", v, 32'd1);
    chk("R7 fault gives -1", ep(exec_prio), 32'h3FF);
    wr(8'd17, 32'h40);
    chk("R7 fault over base", ep(exec_prio), 32'h3FF);
    wr(8'd19, 32'h0);
    chk("R8 pmask over base", ep(exec_prio), 32'd0);
    wr(8'd16, 32'h0);
    chk("R9 base after masks clear", ep(exec_prio), 32'h40);
  endtask

  task automatic t_banks();
    logic [31:0] v;
    do_reset();
    sec_state = 1'b0;
    wr(8'd17, 32'h1234_56A0);
    rd(8'd17, v); chk("R4 ns write read 17", v, 32'hA0);
    rd(8'd18, v); chk("R4 ns read alias 18", v, 32'hA0);
    chk("R9 exec full mask", ep(exec_prio), 32'hA0);
    sec_state = 1'b1;
    rd(8'd17, v); chk("R5 secure bank untouched", v, 32'd0);
    chk("R10 secure bank zero", ep(exec_prio), 32'd256);
    wr(8'd17, 32'h40);
    rd(8'd17, v); chk("R4 s write read", v, 32'h40);
    sec_state = 1'b0;
    rd(8'd17, v); chk("R5 ns bank kept", v, 32'hA0);
    grp_mask = 8'hE0;
    #1 chk("R9 group mask A0", ep(exec_prio), 32'hA0);
    wr(8'd17, 32'h1F);
    chk("R9 sub-priority cleared", ep(exec_prio), 32'd0);
    grp_mask = 8'hFC;
    #1 chk("R9 partial mask", ep(exec_prio), 32'h1C);
  endtask

  task automatic t_raise();
    logic [31:0] v;
    do_reset();
    sec_state = 1'b0;
    wr(8'd18, 32'h0);   rd(8'd17, v); chk("R6 zero ignored", v, 32'd0);
    wr(8'd18, 32'h80);  rd(8'd17, v); chk("R6 from zero", v, 32'h80);
    wr(8'd18, 32'hC0);  rd(8'd17, v); chk("R6 larger ignored", v, 32'h80);
    wr(8'd18, 32'h40);  rd(8'd17, v); chk("R6 smaller taken", v, 32'h40);
    wr(8'd18, 32'h40);  rd(8'd17, v); chk("R6 equal kept", v, 32'h40);
    wr(8'd18, 32'h100); rd(8'd17, v); chk("R6 low byte zero ignored", v, 32'h40);
    wr(8'd17, 32'hC0);  rd(8'd17, v); chk("R4 plain write lowers", v, 32'hC0);
    sec_state = 1'b1;
    wr(8'd18, 32'h20);  rd(8'd18, v); chk("R6 secure bank raise", v, 32'h20);
    sec_state = 1'b0;
    rd(8'd17, v); chk("R5 ns unchanged by secure raise", v, 32'hC0);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    do_reset();
    wr(8'd17, 32'h55);
    wr(8'd20, 32'hFFFF_FFFF);
    wr(8'd15, 32'hFFFF_FFFF);
    wr(8'd0,  32'hFFFF_FFFF);
    rd(8'd16, v); chk("R11 pmask unchanged", v, 32'd0);
    rd(8'd19, v); chk("R11 fault unchanged", v, 32'd0);
    rd(8'd17, v); chk("R11 base unchanged", v, 32'h55);
    rd(8'd20, v); chk("R11 unknown reads zero", v, 32'd0);
    chk("R11 exec unchanged", ep(exec_prio), 32'h55);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk);
    sel = 8'd17; wr_data = 32'h30; wr_en = 1'b1;
    #1 chk("R12 old value before edge", ep(exec_prio), 32'd256);
    @(posedge clk);
    #1 chk("R12 new value after edge", ep(exec_prio), 32'h30);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_nosec();
    do_reset();
    sec_state = 1'b1;
    wr(8'd17, 32'h60);
    sel = 8'd17;
    #1 chk("R13 read with sec=1", rd_data_ns, 32'h60);
    sec_state = 1'b0;
    #1 chk("R13 read with sec=0", rd_data_ns, 32'h60);
    chk("R13 exec single bank", ep(exec_prio_ns), 32'h60);
    chk("R13 banked part sec=0 empty", ep(exec_prio), 32'd256);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_masks();
    t_banks();
    t_raise();
    t_unknown();
    t_timing();
    t_nosec();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule